// File: doc/BRIEF.md
# Strided Vector Register Compressor

This block examines a vector register of 64 lanes of 32 bits on its way to a register file write port. The register arrives as four consecutive beats of 16 adjacent lanes. The block decides whether the whole register can be rebuilt from one base value and at most two small deltas. It checks three patterns. In the first, every lane holds the same value. In the second, each lane is a fixed positive step above the one before it. In the third, the register splits into groups of equal size: lanes step by an inner delta inside a group, and group starts step by an outer delta.

A speculative flag is raised after the first beat when that beat fits a pattern. The flag is narrowed on each later beat, and the verdict is final after the fourth beat. All beats are kept in a full-register buffer. If the register compresses, the write port carries the compact encoding for one cycle. If not, the write port replays the four raw beats on four cycles while a stall holds off new input. A partial-update (divergent) write forces the register to be incompressible.

Top module: `vreg_stride_compressor`

## Requirements
- R1: Each accepted beat (`in_valid` high while `stall` is low) advances the beat count. `done` pulses for exactly one cycle, the cycle after the fourth accepted beat of a register, and at no other time. After reset `spec_ok`, `done`, `wr_valid` and `stall` are low.
- R2: A register whose 64 lanes are all equal gets tag 2'b01, with base set to lane 0 and both deltas zero.
- R3: A register where lane i equals lane0 + i*d (modulo 2^32) gets tag 2'b10. This requires d to be greater than zero as a signed value and to fit in DELTA_W signed bits. The inner delta is d and the outer delta is zero.
- R4: A register where lane i equals lane0 + (i/SUB)*dout + (i%SUB)*din gets tag 2'b11. With the default SUB of 16, din and dout may have any sign but must each fit in DELTA_W signed bits. The inner delta is din and the outer delta is dout.
- R5: The patterns are checked in the priority constant, then single stride, then two-level. A register that fits none of them, or whose deltas overflow DELTA_W, gets tag 2'b00.
- R6: After beat b, `spec_ok` is high exactly when lanes 0 to 16*(b+1)-1 still fit some pattern. After the fourth beat it equals the final verdict.
- R7: When the final tag is not 2'b00, in the `done` cycle `wr_valid` and `wr_cmp` are high and `stall` is low. `wr_data[49:0]` holds {tag[1:0], base[31:0], inner delta[7:0], outer delta[7:0]}, outer delta in the low bits, and the upper bits are zero. `wr_valid` is low the next cycle.
- R8: When the final tag is 2'b00, the four raw beats appear on `wr_data` in arrival order in the `done` cycle and the three cycles after it. `wr_valid` and `stall` are high and `wr_cmp` is low in those cycles, and `stall` and `wr_valid` are low after them.
- R9: Beats presented while `stall` is high are ignored and do not advance the beat count.
- R10: `in_part` high on any beat of a register forces tag 2'b00 and drops `spec_ok` from that beat on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat present on `in_blk` |
| in_blk | input | 512 | Sixteen 32-bit lanes, lane 0 in the low bits |
| in_part | input | 1 | Beat belongs to a partial-update write |
| spec_ok | output | 1 | Speculative/final compressibility flag |
| done | output | 1 | Final verdict pulse |
| done_tag | output | 2 | Final pattern tag |
| wr_valid | output | 1 | Write port data valid |
| wr_cmp | output | 1 | Write port carries the compact encoding |
| wr_data | output | 512 | Encoding or replayed raw beat |
| stall | output | 1 | Replay in progress, input held off |

## Verification
The hardest situation to reach is a register that looks compressible through three beats and fails only on the last lane. The replay then has to recover all four beats from the buffer. Producing it needs a corrupted final lane on a clean stride or constant, and the stimulus injects that corruption on purpose, along with deltas placed right at the signed DELTA_W limit. The bench also drives garbage beats during the replay stall to show they cannot slip into the beat count.

// File: rtl/vsc_pkg.sv
// Shared types for the strided vector register compressor.
package vsc_pkg;
    typedef enum logic [1:0] {
        PAT_NONE   = 2'b00,
        PAT_CONST  = 2'b01,
        PAT_STRIDE = 2'b10,
        PAT_TWO    = 2'b11
    } pat_e;
endpackage

// File: rtl/vsc_block_check.sv
// Evaluates one beat of lanes against the three patterns.
// Assumes BLK >= 2 and that SUB is a multiple of BLK. Values learned on earlier
// beats come in as registered inputs. Purely combinational.
module vsc_block_check #(
    parameter int DW      = 32,
    parameter int BLK     = 16,
    parameter int NBLK    = 4,
    parameter int SUB     = 16,
    parameter int DELTA_W = 8,
    localparam int IW     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic [BLK*DW-1:0] blk,
    input  logic [IW-1:0]     idx,
    input  logic [DW-1:0]     base_r,
    input  logic [DW-1:0]     din_r,
    input  logic [DW-1:0]     dout_r,
    output logic [DW-1:0]     base_e,
    output logic [DW-1:0]     din_e,
    output logic [DW-1:0]     dout_e,
    output logic              ok_const,
    output logic              ok_stride,
    output logic              ok_two
);
    localparam int SPB              = SUB / BLK;
    localparam logic [DW-1:0] SPB_W = DW'(SPB);
    localparam logic [DW-1:0] BLK_W = DW'(BLK);

    // True when x is representable as a DELTA_W-bit signed value.
    function automatic logic fits(input logic [DW-1:0] x);
        return (x[DW-1:DELTA_W-1] == {(DW-DELTA_W+1){1'b0}}) ||
               (x[DW-1:DELTA_W-1] == {(DW-DELTA_W+1){1'b1}});
    endfunction

    logic [DW-1:0]  idx_w, k_w, pos0_w, lin_w, sub_w;
    logic [BLK-1:0] c_eq, s_eq, t_eq;

    // Effective base and deltas, plus each model's value at lane 0 of this beat.
    always_comb begin
        idx_w  = DW'(idx);
        base_e = (idx == '0) ? blk[DW-1:0] : base_r;
        din_e  = (idx == '0) ? (blk[2*DW-1:DW] - blk[DW-1:0]) : din_r;
        dout_e = (idx_w == SPB_W) ? (blk[DW-1:0] - base_r) : dout_r;
        k_w    = idx_w / SPB_W;
        pos0_w = (idx_w % SPB_W) * BLK_W;
        lin_w  = base_e + idx_w * BLK_W * din_e;
        sub_w  = base_e + k_w * dout_e + pos0_w * din_e;
    end

    // Per-lane comparison against the three models.
    for (genvar j = 0; j < BLK; j++) begin : g_lane
        localparam logic [DW-1:0] JW = DW'(j);
        assign c_eq[j] = (blk[j*DW +: DW] == base_e);
        assign s_eq[j] = (blk[j*DW +: DW] == lin_w + JW * din_e);
        assign t_eq[j] = (blk[j*DW +: DW] == sub_w + JW * din_e);
    end

    // Reduce lane matches and apply the delta range rules.
    always_comb begin
        ok_const  = &c_eq;
        ok_stride = (&s_eq) && fits(din_e) && !din_e[DW-1] && (din_e != '0);
        ok_two    = (&t_eq) && fits(din_e) && ((k_w == '0) || fits(dout_e));
    end
endmodule

// File: rtl/vsc_replay.sv
// Full-register beat buffer and write port mux. Buffers every accepted beat.
// On a raw start it replays all beats in order with stall high; on an encoding
// start it presents the compact word for one cycle. Assumes the two starts never
// coincide and that no beat is captured while stall is high.
module vsc_replay #(
    parameter int DW    = 32,
    parameter int BLK   = 16,
    parameter int NBLK  = 4,
    parameter int ENC_W = 50,
    localparam int IW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IW-1:0]     cap_idx,
    input  logic [BLK*DW-1:0] cap_blk,
    input  logic              start_raw,
    input  logic              start_enc,
    input  logic [ENC_W-1:0]  enc,
    output logic              wr_valid,
    output logic              wr_cmp,
    output logic [BLK*DW-1:0] wr_data,
    output logic              stall
);
    localparam logic [IW-1:0] LAST = IW'(NBLK - 1);

    logic [BLK*DW-1:0] store [NBLK];
    logic              rp_act, enc_pend;
    logic [IW-1:0]     rp_idx;
    logic [ENC_W-1:0]  enc_q;

    // Capture each accepted beat into its slot.
    always_ff @(posedge clk) begin
        if (cap_en) store[cap_idx] <= cap_blk;
    end

    // Replay sequencer and one-cycle encoding holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_act   <= 1'b0;
            rp_idx   <= '0;
            enc_pend <= 1'b0;
            enc_q    <= '0;
        end else begin
            enc_pend <= start_enc;
            if (start_enc) enc_q <= enc;
            if (start_raw) begin
                rp_act <= 1'b1;
                rp_idx <= '0;
            end else if (rp_act) begin
                if (rp_idx == LAST) rp_act <= 1'b0;
                rp_idx <= rp_idx + 1'b1;
            end
        end
    end

    // Two-way write port mux: raw replay beat or compact encoding.
    always_comb begin
        stall    = rp_act;
        wr_valid = rp_act || enc_pend;
        wr_cmp   = enc_pend && !rp_act;
        wr_data  = '0;
        if (rp_act) wr_data = store[rp_idx];
        else if (enc_pend) wr_data[ENC_W-1:0] = enc_q;
    end

    // R8: the stall window only ever carries raw data
    a_r8_stall_raw: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (wr_valid && !wr_cmp));
    // R8: a replay lasts longer than one cycle
    a_r8_replay_runs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |=> stall);
endmodule

// File: rtl/vreg_stride_compressor.sv
// Top level: counts beats, tracks the running fit of each pattern, forms the
// speculative flag and final verdict, and drives the buffer/replay unit.
// Assumes LANES is a multiple of BLK, SUB a multiple of BLK that divides LANES,
// and that the encoding is no wider than one beat.
module vreg_stride_compressor #(
    parameter int DW      = 32,
    parameter int LANES   = 64,
    parameter int BLK     = 16,
    parameter int SUB     = 16,
    parameter int DELTA_W = 8,
    localparam int NBLK   = LANES / BLK,
    localparam int IW     = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int BW     = BLK * DW,
    localparam int ENC_W  = 2 + DW + 2 * DELTA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [BW-1:0] in_blk,
    input  logic          in_part,
    output logic          spec_ok,
    output logic          done,
    output logic [1:0]    done_tag,
    output logic          wr_valid,
    output logic          wr_cmp,
    output logic [BW-1:0] wr_data,
    output logic          stall
);
    import vsc_pkg::*;

    logic [IW-1:0]    cnt;
    logic [DW-1:0]    base_r, din_r, dout_r, base_e, din_e, dout_e;
    logic             okc_r, oks_r, okt_r, part_r;
    logic             ok_c, ok_s, ok_t;
    logic             accept, first, last, nc, ns, nt, np;
    pat_e             verdict, done_q;
    logic [ENC_W-1:0] enc_n;

    vsc_block_check #(.DW(DW), .BLK(BLK), .NBLK(NBLK), .SUB(SUB), .DELTA_W(DELTA_W)) u_check (
        .blk(in_blk), .idx(cnt), .base_r(base_r), .din_r(din_r), .dout_r(dout_r),
        .base_e(base_e), .din_e(din_e), .dout_e(dout_e),
        .ok_const(ok_c), .ok_stride(ok_s), .ok_two(ok_t)
    );

    // Running pattern fit including this beat, and the verdict it implies.
    always_comb begin
        accept = in_valid && !stall;
        first  = (cnt == '0);
        last   = (cnt == IW'(NBLK - 1));
        nc     = first ? ok_c    : (okc_r && ok_c);
        ns     = first ? ok_s    : (oks_r && ok_s);
        nt     = first ? ok_t    : (okt_r && ok_t);
        np     = first ? in_part : (part_r || in_part);
        if (np)      verdict = PAT_NONE;
        else if (nc) verdict = PAT_CONST;
        else if (ns) verdict = PAT_STRIDE;
        else if (nt) verdict = PAT_TWO;
        else         verdict = PAT_NONE;
        enc_n = {verdict, base_e,
                 (verdict == PAT_CONST) ? {DELTA_W{1'b0}} : din_e[DELTA_W-1:0],
                 (verdict == PAT_TWO)   ? dout_e[DELTA_W-1:0] : {DELTA_W{1'b0}}};
    end

    // Beat counter, learned base/deltas, running flags and the verdict pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            base_r  <= '0;
            din_r   <= '0;
            dout_r  <= '0;
            okc_r   <= 1'b0;
            oks_r   <= 1'b0;
            okt_r   <= 1'b0;
            part_r  <= 1'b0;
            spec_ok <= 1'b0;
            done    <= 1'b0;
            done_q  <= PAT_NONE;
        end else begin
            done <= accept && last;
            if (accept) begin
                cnt     <= last ? '0 : cnt + 1'b1;
                base_r  <= base_e;
                din_r   <= din_e;
                dout_r  <= first ? '0 : dout_e;
                okc_r   <= nc;
                oks_r   <= ns;
                okt_r   <= nt;
                part_r  <= np;
                spec_ok <= !np && (nc || ns || nt);
                if (last) done_q <= verdict;
            end
        end
    end

    assign done_tag = done_q;

    vsc_replay #(.DW(DW), .BLK(BLK), .NBLK(NBLK), .ENC_W(ENC_W)) u_replay (
        .clk(clk), .rst_n(rst_n),
        .cap_en(accept), .cap_idx(cnt), .cap_blk(in_blk),
        .start_raw(accept && last && (verdict == PAT_NONE)),
        .start_enc(accept && last && (verdict != PAT_NONE)),
        .enc(enc_n),
        .wr_valid(wr_valid), .wr_cmp(wr_cmp), .wr_data(wr_data), .stall(stall)
    );

    // R8: an incompressible verdict starts the replay in the same cycle
    a_r8_none_replays: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_q == PAT_NONE) |-> stall);
    // R7: a compressible verdict drives the encoding with no stall
    a_r7_cmp_emits: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_q != PAT_NONE) |-> (wr_valid && wr_cmp && !stall));
    // R6: the flag agrees with the final verdict
    a_r6_final_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spec_ok == (done_q != PAT_NONE)));
    // R9: no beat is counted during a stall
    a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(cnt));
    // R10: a partial-update beat drops the flag
    a_r10_part_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_part) |=> !spec_ok);
endmodule

// File: tb/test_vreg_stride_compressor.sv
module test_vreg_stride_compressor;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 64;
    localparam int BLK   = 16;
    localparam int BW    = 512;

    logic          clk, rst_n, in_valid, in_part;
    logic [BW-1:0] in_blk;
    logic          spec_ok, done, wr_valid, wr_cmp, stall;
    logic [1:0]    done_tag;
    logic [BW-1:0] wr_data;

    int n_chk = 0, n_fail = 0;
    logic [31:0] v [LANES];

    vreg_stride_compressor i_vreg_stride_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blk(in_blk), .in_part(in_part),
        .spec_ok(spec_ok), .done(done), .done_tag(done_tag),
        .wr_valid(wr_valid), .wr_cmp(wr_cmp), .wr_data(wr_data), .stall(stall)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit fits8(input logic [31:0] x);
        return ($signed(x) >= -128) && ($signed(x) <= 127);
    endfunction

    // Pattern over lanes 0..n-1: 01 const, 10 stride, 11 two-level (groups of 16), 00 none
    function automatic logic [1:0] model(input int n);
        logic [31:0] b, d, dout;
        bit c, s, t;
        b = v[0]; d = v[1] - v[0]; dout = v[16] - v[0];
        c = 1; s = 1; t = 1;
        for (int i = 0; i < n; i++) begin
            if (v[i] != b) c = 0;
            if (v[i] != b + 32'(i) * d) s = 0;
            if (v[i] != b + 32'(i / 16) * dout + 32'(i % 16) * d) t = 0;
        end
        s = s && fits8(d) && ($signed(d) > 0);
        t = t && fits8(d) && ((n <= 16) || fits8(dout));
        if (c) return 2'b01;
        if (s) return 2'b10;
        if (t) return 2'b11;
        return 2'b00;
    endfunction

    function automatic logic [BW-1:0] blk_of(input int b);
        logic [BW-1:0] r;
        for (int j = 0; j < BLK; j++) r[j*32 +: 32] = v[b*BLK + j];
        return r;
    endfunction

    function automatic logic [BW-1:0] enc_of(input logic [1:0] tag);
        logic [BW-1:0] r;
        logic [7:0] d1, d2;
        d1 = (tag == 2'b01) ? 8'h0 : 8'(v[1] - v[0]);
        d2 = (tag == 2'b11) ? 8'(v[16] - v[0]) : 8'h0;
        r = '0;
        r[49:0] = {tag, v[0], d1, d2};
        return r;
    endfunction

    function automatic string req_of(input logic [1:0] tag);
        case (tag)
            2'b01: return "R2";
            2'b10: return "R3";
            2'b11: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic fill_lin(input logic [31:0] b, input logic [31:0] d);
        for (int i = 0; i < LANES; i++) v[i] = b + 32'(i) * d;
    endtask

    task automatic fill_two(input logic [31:0] b, input logic [31:0] din, input logic [31:0] dout);
        for (int i = 0; i < LANES; i++) v[i] = b + 32'(i / 16) * dout + 32'(i % 16) * din;
    endtask

    task automatic fill_rand();
        for (int i = 0; i < LANES; i++) v[i] = $urandom;
    endtask

    // Send one register and check flag, verdict and write port cycle by cycle.
    task automatic run_reg(input int part_beat, input bit poke);
        logic [1:0] exp_tag;
        bit exp_flag;
        exp_tag = (part_beat >= 0) ? 2'b00 : model(64);
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            if (b > 0) begin
                exp_flag = !(part_beat >= 0 && b - 1 >= part_beat) && (model(16 * b) != 2'b00);
                chk(spec_ok == exp_flag, (part_beat >= 0 && b - 1 >= part_beat) ? "R10" : "R6",
                    "spec flag", BW'(spec_ok), BW'(exp_flag));
                chk(done == 1'b0, "R9", "no early done", BW'(done), '0);
            end
            in_valid = 1'b1;
            in_blk   = blk_of(b);
            in_part  = (b == part_beat);
        end
        @(negedge clk);
        in_valid = 1'b0; in_part = 1'b0;
        chk(spec_ok == (exp_tag != 2'b00), "R6", "final flag", BW'(spec_ok), BW'(exp_tag != 2'b00));
        chk(done == 1'b1, "R1", "done pulse", BW'(done), BW'(1));
        chk(done_tag == exp_tag, (part_beat >= 0) ? "R10" : req_of(exp_tag), "tag",
            BW'(done_tag), BW'(exp_tag));
        if (exp_tag != 2'b00) begin
            chk(wr_valid && wr_cmp && !stall, "R7", "enc strobe", {wr_valid, wr_cmp, stall}, 3'b110);
            chk(wr_data == enc_of(exp_tag), "R7", "enc word", wr_data, enc_of(exp_tag));
            @(negedge clk);
            chk(!wr_valid && !done, "R7", "single cycle", {wr_valid, done}, '0);
        end else begin
            for (int r = 0; r < 4; r++) begin
                if (r > 0) @(negedge clk);
                chk(stall && wr_valid && !wr_cmp, "R8", "replay strobe", {stall, wr_valid, wr_cmp}, 3'b110);
                chk(wr_data == blk_of(r), "R8", "replay beat", wr_data, blk_of(r));
                if (poke) begin
                    in_valid = (r < 3);
                    in_blk   = ~blk_of(r);
                end
            end
            @(negedge clk);
            in_valid = 1'b0;
            chk(!stall && !wr_valid, "R8", "replay end", {stall, wr_valid}, '0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h1234_5eed);
        rst_n = 1'b0; in_valid = 1'b0; in_part = 1'b0; in_blk = '0;
        repeat (3) @(negedge clk);
        chk(!spec_ok && !done && !wr_valid && !stall, "R1", "reset state",
            {spec_ok, done, wr_valid, stall}, '0);
        rst_n = 1'b1;

        fill_lin(32'h0000_00aa, 32'h0);           run_reg(-1, 0);  // R2 constant
        fill_lin(32'h0000_1000, 32'h1);           run_reg(-1, 0);  // R3 unit stride
        fill_lin(32'hffff_fff0, 32'd127);         run_reg(-1, 0);  // R3 max delta, wrap
        fill_lin(32'h10, 32'd128);                run_reg(-1, 1);  // R5 overflow, R9 poke
        fill_lin(32'h500, 32'hffff_fffd);         run_reg(-1, 0);  // R4 negative linear
        fill_two(32'h2000, 32'd2, 32'd100);       run_reg(-1, 0);  // R4 two-level
        fill_two(32'h2000, 32'd2, 32'd300);       run_reg(-1, 0);  // R5 outer overflow
        fill_lin(32'h40, 32'd4); v[63] = 32'h0;   run_reg(-1, 1);  // R5 late miss
        fill_lin(32'h7, 32'h0); v[20] = 32'h8;    run_reg(-1, 0);  // R6 miss in beat 1
        fill_lin(32'h40, 32'd4);                  run_reg(2, 0);   // R10 divergent beat 2
        fill_lin(32'h77, 32'h0);                  run_reg(0, 0);   // R10 divergent beat 0

        for (int it = 0; it < 60; it++) begin
            int kind, pb;
            kind = int'($urandom % 5);
            case (kind)
                0: fill_lin($urandom, 32'h0);
                1: fill_lin($urandom, 32'($urandom % 130));
                2: fill_lin($urandom, 32'(int'($urandom % 401) - 200));
                3: fill_two($urandom, 32'(int'($urandom % 301) - 150), 32'(int'($urandom % 301) - 150));
                default: fill_rand();
            endcase
            if ($urandom % 4 == 0) v[$urandom % LANES] = $urandom;
            pb = ($urandom % 8 == 0) ? int'($urandom % 4) : -1;
            run_reg(pb, ($urandom % 4) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule